// File: doc/BRIEF.md
# Performance Counter Global Control Unit

This unit keeps a small bank of event counters for performance monitoring: four general-purpose counters and three fixed-function counters, each 48 bits wide. A counter advances by one on each clock in which its event input is high, but only if two conditions hold. Its bit in a shared enable word must be set, and its local qualifier must allow counting in the current privilege mode. Each counter has a user qualifier and a supervisor qualifier. When a counter wraps from all-ones to zero, its overflow flag is set. If that counter's interrupt enable is set, a one-cycle interrupt pulse is also raised.

A debug-control word sets what happens on an overflow. One option freezes every counter until software releases the freeze. A second option only records a branch-record freeze flag for a neighbouring trace block. Two further status flags mirror overflow signals that arrive on pins from outside the unit. A sticky condition-changed flag at the top of the status word records that some other status bit has moved.

Software reaches everything through one address/data port. Writes take one clock and reads are combinational. Status flags are cleared by writing ones to a separate clear address.

Top module: `pmu_global_unit`

## Requirements
- R1: Counter k increments on a clock where its event input is high only if all of the following hold:
  - its global enable bit is 1;
  - the freeze flag is clear;
  - the qualifier for the current mode is 1: the user qualifier (local control bit 0) when `user_mode`=1, or the supervisor qualifier (bit 1) when `user_mode`=0.
- R2: The global enable word (address 0) holds general-purpose enables at bits 0..3 and fixed enables at bits 32..34. Writes to any other bit are dropped, and those bits read as zero.
- R3: Counter values are written and read at addresses 4..10: general-purpose 0..3 first, then fixed 0..2.
  - Only the low 48 bits of a write are kept.
  - A write wins over a same-cycle increment.
- R4: A counter that wraps from all-ones to zero sets its overflow status bit in the same clock edge. General-purpose counters use bits 0..3 and fixed counters use bits 32..34 of the status word (address 1).
- R5: Writing 1 to bit i of the clear address (address 2) clears status bit i. Bits written as 0 leave status unchanged.
- R6: `pmi` is high for exactly one cycle, the cycle after a wrap edge, when the wrapping counter's interrupt enable (local control bit 2) is set. A wrap without that enable raises no pulse.
- R7: With debug-control bit 1 set, any wrap sets status bit 59. While bit 59 is set, no counter advances. Clearing bit 59 through the clear address resumes counting on the next cycle.
- R8: With debug-control bit 0 (address 3) set, any wrap sets status bit 58. Bit 58 does not stop counting.
- R9: Status bits 61 and 62 follow the `uncore_ovf` and `sbuf_ovf` pins one cycle later. Writes to the clear address do not affect them.
- R10: Status bit 63 is set on any edge where another status bit changes. It is cleared by writing 1 to bit 63 of the clear address, unless another status bit changes in that same edge.
- R11: After reset, all counters, control words, status bits and `pmi` are zero.

Local control layout:
- General-purpose counter k has its own local control word at address 11+k.
- Fixed counter j has a 3-bit field at bits 4j+2..4j of address 15.
- Within each field, bit 0 is the user qualifier, bit 1 the supervisor qualifier and bit 2 the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data for `addr` |
| user_mode | input | 1 | Current privilege mode, 1 = user, 0 = supervisor |
| gp_event | input | 4 | Event inputs of the general-purpose counters |
| fix_event | input | 3 | Event inputs of the fixed counters |
| uncore_ovf | input | 1 | External counter overflow indication |
| sbuf_ovf | input | 1 | Sample-buffer overflow indication |
| pmi | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The assertions cover the rules that hold on every cycle:
- counters hold still while frozen;
- a wrap always lands in its overflow bit;
- every interrupt pulse has an enabled wrap behind it;
- the condition-changed flag accompanies each status movement;
- the pin-driven bits track their inputs;
- reserved enable bits read as zero.

Only the bench scenarios can show the rest:
- the exact counts under each mix of enable, qualifier and mode;
- write-over-increment priority;
- the write-one-to-clear semantics, including the re-arming of bit 63;
- resumption after a freeze is released;
- the fact that branch-record freeze leaves counting alone.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int NUM_GP     = 4;
  localparam int NUM_FIX    = 3;
  localparam int NUM_CTR    = NUM_GP + NUM_FIX;
  localparam int CTR_W      = 48;
  localparam int DW         = 64;
  localparam int FIX_EN_LSB = 32;
  localparam int FIX_FLD_W  = 4;

  // address map
  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_CLR   = 2;
  localparam int A_DBG   = 3;
  localparam int A_CTR0  = 4;
  localparam int A_GPL0  = A_CTR0 + NUM_CTR;
  localparam int A_FIXL  = A_GPL0 + NUM_GP;
  localparam int ADDR_W  = $clog2(A_FIXL + 1);

  // status word positions
  localparam int S_BRF = 58;
  localparam int S_FRZ = 59;
  localparam int S_UNC = 61;
  localparam int S_BUF = 62;
  localparam int S_CHG = 63;

  typedef struct packed {
    logic ie;
    logic os;
    logic usr;
  } lctl_t;

  // bit position shared by enable word and status word for counter k
  function automatic int ctr_bit(input int k);
    return (k < NUM_GP) ? k : FIX_EN_LSB + k - NUM_GP;
  endfunction

  function automatic logic [DW-1:0] ctrl_mask_f();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CTR; k++) m[ctr_bit(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] CTRL_MASK = ctrl_mask_f();

endpackage

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_ev,
  input  logic         glb_en,
  input  logic         q_usr,
  input  logic         q_os,
  input  logic         user_mode,
  input  logic         frozen,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val,
  output logic         wrap
);

  logic [W-1:0] val_q, val_nxt;
  logic         adv, ce;

  always_comb begin
    adv     = cnt_ev & glb_en & ~frozen & (user_mode ? q_usr : q_os);
    ce      = wr_en | adv;
    val_nxt = wr_en ? wr_val : val_q + W'(1);
    wrap    = adv & ~wr_en & (&val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (ce) val_q <= val_nxt;
  end

  assign val = val_q;

endmodule

// File: rtl/pmu_stat.sv
module pmu_stat
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic [NUM_CTR-1:0] ie,
  input  logic               brf_en,
  input  logic               frz_en,
  input  logic               unc_in,
  input  logic               buf_in,
  input  logic [NUM_CTR-1:0] clr_ovf,
  input  logic               clr_brf,
  input  logic               clr_frz,
  input  logic               clr_chg,
  output logic [NUM_CTR-1:0] ovf,
  output logic               frozen,
  output logic               pmi,
  output logic [DW-1:0]      stat
);

  logic [NUM_CTR-1:0] ovf_q, ovf_nxt;
  logic brf_q, brf_nxt, frz_q, frz_nxt;
  logic unc_q, buf_q, chg_q, chg_nxt, pmi_q, pmi_nxt;
  logic any_wrap;

  always_comb begin
    any_wrap = |wrap;
    ovf_nxt  = (ovf_q & ~clr_ovf) | wrap;
    brf_nxt  = (brf_q & ~clr_brf) | (brf_en & any_wrap);
    frz_nxt  = (frz_q & ~clr_frz) | (frz_en & any_wrap);
    chg_nxt  = (chg_q & ~clr_chg) |
               ({ovf_nxt, brf_nxt, frz_nxt, unc_in, buf_in} !=
                {ovf_q,   brf_q,   frz_q,   unc_q,  buf_q});
    pmi_nxt  = |(wrap & ie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      brf_q <= 1'b0;
      frz_q <= 1'b0;
      unc_q <= 1'b0;
      buf_q <= 1'b0;
      chg_q <= 1'b0;
      pmi_q <= 1'b0;
    end else begin
      ovf_q <= ovf_nxt;
      brf_q <= brf_nxt;
      frz_q <= frz_nxt;
      unc_q <= unc_in;
      buf_q <= buf_in;
      chg_q <= chg_nxt;
      pmi_q <= pmi_nxt;
    end
  end

  always_comb begin
    stat = '0;
    for (int k = 0; k < NUM_CTR; k++) stat[ctr_bit(k)] = ovf_q[k];
    stat[S_BRF] = brf_q;
    stat[S_FRZ] = frz_q;
    stat[S_UNC] = unc_q;
    stat[S_BUF] = buf_q;
    stat[S_CHG] = chg_q;
  end

  assign ovf    = ovf_q;
  assign frozen = frz_q;
  assign pmi    = pmi_q;

endmodule

// File: rtl/pmu_global_unit.sv
module pmu_global_unit
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              user_mode,
  input  logic [NUM_GP-1:0] gp_event,
  input  logic [NUM_FIX-1:0] fix_event,
  input  logic              uncore_ovf,
  input  logic              sbuf_ovf,
  output logic              pmi
);

  logic [DW-1:0]            ctrl_q, ctrl_nxt;
  logic [1:0]               dbg_q;
  lctl_t                    lctl_q [NUM_CTR];
  logic [NUM_CTR-1:0]       ctr_ev, ctr_we, wrap_w, ie_w, clr_ovf, ovf_w;
  logic [NUM_CTR*CTR_W-1:0] ctr_flat;
  logic [DW-1:0]            stat_w;
  logic                     frozen_w, ctrl_we, dbg_we, clr_we;

  assign ctrl_we  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign dbg_we   = wr_en && (addr == ADDR_W'(A_DBG));
  assign clr_we   = wr_en && (addr == ADDR_W'(A_CLR));
  assign ctrl_nxt = wdata & CTRL_MASK;
  assign ctr_ev   = {fix_event, gp_event};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_q <= '0;
    else if (dbg_we) dbg_q <= wdata[1:0];
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic  lctl_we;
    lctl_t lctl_nxt;

    if (k < NUM_GP) begin : g_gp
      assign lctl_we  = wr_en && (addr == ADDR_W'(A_GPL0 + k));
      assign lctl_nxt = lctl_t'(wdata[2:0]);
    end else begin : g_fix
      assign lctl_we  = wr_en && (addr == ADDR_W'(A_FIXL));
      assign lctl_nxt = lctl_t'(wdata[FIX_FLD_W*(k-NUM_GP) +: 3]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lctl_q[k] <= '0;
      else if (lctl_we) lctl_q[k] <= lctl_nxt;
    end

    assign ctr_we[k]  = wr_en && (addr == ADDR_W'(A_CTR0 + k));
    assign ie_w[k]    = lctl_q[k].ie;
    assign clr_ovf[k] = clr_we & wdata[ctr_bit(k)];

    pmu_ctr #(.W(CTR_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_ev    (ctr_ev[k]),
      .glb_en    (ctrl_q[ctr_bit(k)]),
      .q_usr     (lctl_q[k].usr),
      .q_os      (lctl_q[k].os),
      .user_mode (user_mode),
      .frozen    (frozen_w),
      .wr_en     (ctr_we[k]),
      .wr_val    (wdata[CTR_W-1:0]),
      .val       (ctr_flat[k*CTR_W +: CTR_W]),
      .wrap      (wrap_w[k])
    );
  end

  pmu_stat i_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap_w),
    .ie      (ie_w),
    .brf_en  (dbg_q[0]),
    .frz_en  (dbg_q[1]),
    .unc_in  (uncore_ovf),
    .buf_in  (sbuf_ovf),
    .clr_ovf (clr_ovf),
    .clr_brf (clr_we & wdata[S_BRF]),
    .clr_frz (clr_we & wdata[S_FRZ]),
    .clr_chg (clr_we & wdata[S_CHG]),
    .ovf     (ovf_w),
    .frozen  (frozen_w),
    .pmi     (pmi),
    .stat    (stat_w)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL)) rdata = ctrl_q;
    if (addr == ADDR_W'(A_STAT)) rdata = stat_w;
    if (addr == ADDR_W'(A_DBG))  rdata = {{(DW-2){1'b0}}, dbg_q};
    for (int k = 0; k < NUM_CTR; k++) begin
      if (addr == ADDR_W'(A_CTR0 + k))
        rdata = {{(DW-CTR_W){1'b0}}, ctr_flat[k*CTR_W +: CTR_W]};
      if (k < NUM_GP && addr == ADDR_W'(A_GPL0 + k))
        rdata = {{(DW-3){1'b0}}, lctl_q[k]};
      if (k >= NUM_GP && addr == ADDR_W'(A_FIXL))
        rdata[FIX_FLD_W*(k-NUM_GP) +: 3] = lctl_q[k];
    end
  end

endmodule

// File: rtl/pmu_global_unit_chk.sv
module pmu_global_unit_chk
  import pmu_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        addr,
  input logic [DW-1:0]            rdata,
  input logic                     pmi,
  input logic                     uncore_ovf,
  input logic                     sbuf_ovf,
  input logic [DW-1:0]            stat,
  input logic [NUM_CTR-1:0]       ovf,
  input logic                     frozen,
  input logic [NUM_CTR-1:0]       wrap,
  input logic [NUM_CTR-1:0]       ie,
  input logic [NUM_CTR-1:0]       ctr_we,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat
);

  // R7
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && (ctr_we == '0)) |=> $stable(ctr_flat));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap != '0) |=> ((ovf & $past(wrap)) == $past(wrap)));

  // R6
  pmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmi |-> $past((wrap & ie) != '0));

  // R10
  chg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_CHG-1:0] != $past(stat[S_CHG-1:0])) |-> stat[S_CHG]);

  // R9
  pin_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat[S_UNC] == $past(uncore_ovf) &&
                      stat[S_BUF] == $past(sbuf_ovf)));

  // R2
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_CTRL)) |-> ((rdata & ~CTRL_MASK) == '0));

endmodule

bind pmu_global_unit pmu_global_unit_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .rdata      (rdata),
  .pmi        (pmi),
  .uncore_ovf (uncore_ovf),
  .sbuf_ovf   (sbuf_ovf),
  .stat       (stat_w),
  .ovf        (ovf_w),
  .frozen     (frozen_w),
  .wrap       (wrap_w),
  .ie         (ie_w),
  .ctr_we     (ctr_we),
  .ctr_flat   (ctr_flat)
);

// File: tb/test_pmu_global_unit.sv
module test_pmu_global_unit;
  import pmu_pkg::*;

  localparam int CLK_P = 10;
  localparam logic [63:0] MAXV = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] CHG  = 64'h8000_0000_0000_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [63:0]       wdata, rdata;
  logic              user_mode;
  logic [NUM_GP-1:0] gp_event;
  logic [NUM_FIX-1:0] fix_event;
  logic              uncore_ovf, sbuf_ovf, pmi;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  pmu_global_unit i_pmu_global_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .user_mode(user_mode), .gp_event(gp_event),
    .fix_event(fix_event), .uncore_ovf(uncore_ovf), .sbuf_ovf(sbuf_ovf),
    .pmi(pmi)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string tag, input int a, input logic [63:0] exp);
    addr = ADDR_W'(a);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run_ev(input logic [NUM_GP-1:0] g, input logic [NUM_FIX-1:0] f, input int n);
    @(negedge clk);
    gp_event = g; fix_event = f;
    repeat (n) @(negedge clk);
    gp_event = '0; fix_event = '0;
  endtask

  task automatic clear_all();
    wr(A_CLR, '1);
    wr(A_CLR, CHG);
  endtask

  task automatic t_reset();
    rd("R11 ctrl", A_CTRL, 0);
    rd("R11 status", A_STAT, 0);
    rd("R11 ctr0", A_CTR0, 0);
    rd("R11 fixl", A_FIXL, 0);
    chk("R11 pmi", {63'b0, pmi}, 0);
  endtask

  task automatic t_ctrl_rsv();
    wr(A_CTRL, '1);
    rd("R2 ctrl reserved", A_CTRL, 64'h0000_0007_0000_000F);
    wr(A_CTRL, 0);
  endtask

  task automatic t_gating();
    wr(A_GPL0, 1); wr(A_GPL0 + 1, 1);
    wr(A_CTRL, 64'h1);
    user_mode = 1'b1;
    run_ev(4'b0011, 3'b000, 5);
    rd("R1 gp0 user count", A_CTR0, 5);
    rd("R1 gp1 disabled", A_CTR0 + 1, 0);
    user_mode = 1'b0;
    run_ev(4'b0011, 3'b000, 3);
    rd("R1 gp0 supervisor blocked", A_CTR0, 5);
    wr(A_GPL0, 3);
    run_ev(4'b0011, 3'b000, 2);
    rd("R1 gp0 supervisor allowed", A_CTR0, 7);
    wr(A_FIXL, 64'h21);
    wr(A_CTRL, 64'h3_0000_0000);
    run_ev(4'b0000, 3'b011, 4);
    rd("R1 fix0 user-only in supervisor", A_CTR0 + NUM_GP, 0);
    rd("R1 fix1 supervisor", A_CTR0 + NUM_GP + 1, 4);
  endtask

  task automatic t_write();
    wr(A_CTR0 + 2, 64'h1234);
    rd("R3 readback", A_CTR0 + 2, 64'h1234);
    wr(A_CTR0 + 2, 64'hFFFF_0000_0000_0005);
    rd("R3 upper bits dropped", A_CTR0 + 2, 5);
    wr(A_GPL0 + 2, 1);
    wr(A_CTRL, 64'h4);
    user_mode = 1'b1;
    @(negedge clk);
    gp_event = 4'b0100; wr_en = 1'b1; addr = ADDR_W'(A_CTR0 + 2); wdata = 100;
    @(negedge clk);
    wr_en = 1'b0; gp_event = '0; wdata = '0;
    rd("R3 write beats increment", A_CTR0 + 2, 100);
  endtask

  task automatic t_ovf();
    wr(A_CTR0 + 1, MAXV - 1);
    wr(A_GPL0 + 1, 5);
    wr(A_CTRL, 64'h2);
    user_mode = 1'b1;
    run_ev(4'b0010, 3'b000, 2);
    chk("R6 pmi pulse", {63'b0, pmi}, 1);
    rd("R4 wrapped value", A_CTR0 + 1, 0);
    rd("R4 status bit", A_STAT, CHG | 64'h2);
    @(negedge clk);
    chk("R6 pmi one cycle", {63'b0, pmi}, 0);
  endtask

  task automatic t_w1c();
    wr(A_CLR, 0);
    rd("R5 zero write no effect", A_STAT, CHG | 64'h2);
    wr(A_CLR, CHG);
    rd("R10 changed cleared", A_STAT, 64'h2);
    wr(A_CLR, 64'h2);
    rd("R5 ovf cleared, R10 re-armed", A_STAT, CHG);
    wr(A_CLR, CHG);
    rd("R10 all clear", A_STAT, 0);
    rd("R5 clear address reads zero", A_CLR, 0);
  endtask

  task automatic t_pmi_noie();
    wr(A_CTR0 + NUM_GP + 1, MAXV);
    wr(A_FIXL, 64'h20);
    wr(A_CTRL, 64'h2_0000_0000);
    user_mode = 1'b0;
    run_ev(4'b0000, 3'b010, 1);
    chk("R6 no pulse without enable", {63'b0, pmi}, 0);
    rd("R4 fixed ovf bit", A_STAT, CHG | 64'h2_0000_0000);
    clear_all();
  endtask

  task automatic t_freeze();
    wr(A_DBG, 2);
    wr(A_CTR0, 0);
    wr(A_CTR0 + 2, MAXV);
    wr(A_GPL0, 1); wr(A_GPL0 + 2, 1);
    wr(A_CTRL, 64'h5);
    user_mode = 1'b1;
    run_ev(4'b0101, 3'b000, 3);
    rd("R7 frozen status", A_STAT, CHG | 64'h0800_0000_0000_0004);
    rd("R7 gp0 stopped", A_CTR0, 1);
    rd("R7 gp2 stopped", A_CTR0 + 2, 0);
    wr(A_CLR, 64'h0800_0000_0000_0000);
    run_ev(4'b0001, 3'b000, 2);
    rd("R7 resumed", A_CTR0, 3);
    clear_all();
    wr(A_DBG, 0);
  endtask

  task automatic t_brf();
    wr(A_DBG, 1);
    wr(A_CTR0, MAXV);
    run_ev(4'b0001, 3'b000, 1);
    rd("R8 branch freeze status", A_STAT, CHG | 64'h0400_0000_0000_0001);
    run_ev(4'b0001, 3'b000, 1);
    rd("R8 counting continues", A_CTR0, 1);
    clear_all();
    wr(A_DBG, 0);
  endtask

  task automatic t_pins();
    @(negedge clk); uncore_ovf = 1'b1;
    @(negedge clk);
    rd("R9 uncore bit", A_STAT, CHG | 64'h2000_0000_0000_0000);
    uncore_ovf = 1'b0; sbuf_ovf = 1'b1;
    @(negedge clk);
    rd("R9 buffer bit", A_STAT, CHG | 64'h4000_0000_0000_0000);
    wr(A_CLR, CHG | 64'h4000_0000_0000_0000);
    rd("R9 pin bit not cleared", A_STAT, 64'h4000_0000_0000_0000);
    sbuf_ovf = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; user_mode = 1'b0;
    gp_event = '0; fix_event = '0; uncore_ovf = 1'b0; sbuf_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rsv();
    t_gating();
    t_write();
    t_ovf();
    t_w1c();
    t_pmi_noie();
    t_freeze();
    t_brf();
    t_pins();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule